// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Register Bank

This block is a three-pin serial slave for a fractional-N synthesizer's control logic. A host moves a 32-bit word in one bit per rising edge of a serial clock, most significant bit first, and then raises a load strobe. The three lowest bits of the word pick one of eight internal registers as the destination. The serial pins are asynchronous to the block's system clock. Each pin passes through a two-flop synchronizer, and the block detects edges in the system clock domain.

Register 0 carries the values that take effect at once: sweep enable, output-select code, integer divide value and the upper part of the fractional value. Registers 1 and 2 carry settings that must change together with register 0: the lower fractional bits, the reference counter, the reference doubler, the reference halver and the pump current code. A write to register 1 or 2 only fills a shadow copy of these settings. The next register 0 write copies every shadowed value to the outputs in the same cycle as register 0's own fields. The 25-bit fractional output joins the 12 upper bits from register 0 with the 13 lower bits from register 1.

On each register 0 write, the block also emits a one-cycle pulse that resets a downstream sigma-delta modulator. A hold bit in register 3 suppresses this pulse. Registers 3 to 7 are stored and presented as raw payloads.

Top module: `sbk_top`

## Requirements
- R1: After reset, every output is zero, including all shadow settings and the modulator reset pulse.
- R2: Bits are shifted in MSB first, one per rising edge of `ser_clk_i`. A rising edge of `ser_ld_i` delivers the last 32 bits to the register whose number is in word bits 2:0.
- R3: A register 0 write sets `sweep_en_o` from bit 31, `obs_sel_o` from bits 30:27, `int_o` from bits 26:15, and the upper 12 bits of the fractional value from bits 14:3.
- R4: `frac_o` equals the register 1 lower part plus the register 0 upper part times 2^13. The lower 13 bits come from register 1 bits 27:15.
- R5: The register 1 fractional lower bits and the register 2 fields are double-buffered. The register 2 fields are pump code in bits 27:24, halver in bit 21, doubler in bit 20 and reference count in bits 19:15. A write to register 1 or 2 leaves these outputs unchanged. The next register 0 write updates all of them in the same cycle.
- R6: The step divider in register 2 bits 14:3 is not buffered and appears on `step_div_o` on the register 2 write itself.
- R7: Each register 0 write produces a single-cycle `sdm_rst_o` pulse when register 3 bit 14 is 0, and no pulse when that bit is 1.
- R8: A write to register k (3 to 7) places word bits 31:3 on `aux_o[k-3]` at once.
- R9: A register write becomes visible on the outputs three system clock rising edges after the `ser_ld_i` pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_ld_i | input | 1 | Load strobe, asynchronous |
| sweep_en_o | output | 1 | Active sweep enable |
| obs_sel_o | output | 4 | Active output-select code |
| int_o | output | 12 | Active integer divide value |
| frac_o | output | 25 | Active fractional value |
| ref_cnt_o | output | 5 | Active reference count (buffered) |
| pump_cur_o | output | 4 | Active pump current code (buffered) |
| ref_half_o | output | 1 | Active reference halver (buffered) |
| ref_dbl_o | output | 1 | Active reference doubler (buffered) |
| step_div_o | output | 12 | Step divider value |
| aux_o | output | 5x29 | Payloads of registers 3 to 7 |
| sdm_rst_o | output | 1 | One-cycle modulator reset pulse |

## Verification
The bench drives each pin change just after a falling system clock edge. The load strobe passes through two synchronizer flops and one register stage, so every output from a write is due at the third rising edge after the strobe rises. The modulator pulse must be high in the cycle after that edge and low in the following one. For each write, the driver queues one expected item with its due cycle and a second item one cycle later. The monitor samples at the falling edge of exactly those cycles. The check on the second item is what shows the pulse lasts one cycle. The checks also confirm that writes to registers 1 and 2 leave the buffered outputs untouched until register 0 is written.

// File: rtl/sbk_pkg.sv
// Shared widths, field positions and the shadow record for the serial register bank.
// Assumes a 3-bit register number in the low bits of every word.
package sbk_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int NUM_REG  = 1 << ADDR_W;
    localparam int NUM_AUX  = NUM_REG - 3;
    localparam int PAY_W    = WORD_W - ADDR_W;
    localparam int FMSB_W   = 12;
    localparam int FLSB_W   = 13;
    localparam int FRAC_W   = FMSB_W + FLSB_W;
    localparam int INT_W    = 12;
    localparam int OBS_W    = 4;
    localparam int PUMP_W   = 4;
    localparam int RCNT_W   = 5;
    localparam int STEP_W   = 12;
    // Function-register bit that suppresses the modulator reset, indexed within the payload.
    localparam int HOLD_IDX = 14 - ADDR_W;

    // Settings that wait in a shadow stage until the next register 0 write.
    typedef struct packed {
        logic [FLSB_W-1:0] frac_lsb;
        logic [RCNT_W-1:0] rcnt;
        logic [PUMP_W-1:0] pump;
        logic              half;
        logic              dbl;
    } dbuf_t;
endpackage

// File: rtl/sbk_sync_edge.sv
// Synchronizes W asynchronous pins with a parameterized flop chain and flags rising edges.
// Assumes each pin is held stable for several system clock periods.
module sbk_sync_edge #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    // First synchronizer flop.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= pin_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Remaining synchronizer flops.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    // Delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= stg[STAGES-1];
    end

    assign lvl_o  = stg[STAGES-1];
    assign rise_o = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/sbk_shifter.sv
// Collects serial bits MSB first and presents the word with a strobe on the load edge.
// Assumes synchronized data and edge flags from the same chain depth.
module sbk_shifter
    import sbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              shift_i,
    input  logic              load_i,
    output logic [WORD_W-1:0] word_o,
    output logic              stb_o
);
    logic [WORD_W-1:0] sr;

    // Shift one bit in on each serial clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr <= '0;
        else if (shift_i) sr <= {sr[WORD_W-2:0], bit_i};
    end

    assign word_o = sr;
    assign stb_o  = load_i;
endmodule

// File: rtl/sbk_regfile.sv
// Decodes completed words into eight registers. Registers 1 and 2 hold buffered settings
// that commit on a register 0 write. The modulator reset pulse is produced here.
// Assumes one strobe per word; strobes are many cycles apart.
module sbk_regfile
    import sbk_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_stb_i,
    input  logic [WORD_W-1:0]              wr_word_i,
    output logic                           sweep_en_o,
    output logic [OBS_W-1:0]               obs_sel_o,
    output logic [INT_W-1:0]               int_o,
    output logic [FRAC_W-1:0]              frac_o,
    output logic [RCNT_W-1:0]              ref_cnt_o,
    output logic [PUMP_W-1:0]              pump_cur_o,
    output logic                           ref_half_o,
    output logic                           ref_dbl_o,
    output logic [STEP_W-1:0]              step_div_o,
    output logic [NUM_AUX-1:0][PAY_W-1:0]  aux_o,
    output logic                           sdm_rst_o
);
    logic [ADDR_W-1:0] addr;
    logic [FMSB_W-1:0] frac_msb;
    dbuf_t             shadow;
    dbuf_t             active;

    assign addr = wr_word_i[ADDR_W-1:0];

    // Register 0 fields plus commit of all shadowed settings; modulator pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_en_o <= 1'b0;
            obs_sel_o  <= '0;
            int_o      <= '0;
            frac_msb   <= '0;
            active     <= '0;
            sdm_rst_o  <= 1'b0;
        end else begin
            sdm_rst_o <= 1'b0;
            if (wr_stb_i && addr == ADDR_W'(0)) begin
                sweep_en_o <= wr_word_i[31];
                obs_sel_o  <= wr_word_i[30:27];
                int_o      <= wr_word_i[26:15];
                frac_msb   <= wr_word_i[14:3];
                active     <= shadow;
                sdm_rst_o  <= ~aux_o[0][HOLD_IDX];
            end
        end
    end

    // Shadow capture for register 1 and the buffered part of register 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_stb_i && addr == ADDR_W'(1)) begin
            shadow.frac_lsb <= wr_word_i[27:15];
        end else if (wr_stb_i && addr == ADDR_W'(2)) begin
            shadow.pump <= wr_word_i[27:24];
            shadow.half <= wr_word_i[21];
            shadow.dbl  <= wr_word_i[20];
            shadow.rcnt <= wr_word_i[19:15];
        end
    end

    // Unbuffered step divider from register 2.
    always_ff @(posedge clk) begin
        if (!rst_n)                               step_div_o <= '0;
        else if (wr_stb_i && addr == ADDR_W'(2)) step_div_o <= wr_word_i[14:3];
    end

    for (genvar k = 0; k < NUM_AUX; k++) begin : g_aux
        // Raw payload for register k+3.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 aux_o[k] <= '0;
            else if (wr_stb_i && addr == ADDR_W'(k + 3)) aux_o[k] <= wr_word_i[WORD_W-1:ADDR_W];
        end
    end

    assign frac_o     = {frac_msb, active.frac_lsb};
    assign ref_cnt_o  = active.rcnt;
    assign pump_cur_o = active.pump;
    assign ref_half_o = active.half;
    assign ref_dbl_o  = active.dbl;
endmodule

// File: rtl/sbk_top.sv
// Serial configuration register bank: synchronizer, shifter and double-buffered register file.
// Assumes asynchronous serial pins, each held for at least three system clocks per phase.
module sbk_top
    import sbk_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ser_clk_i,
    input  logic                          ser_dat_i,
    input  logic                          ser_ld_i,
    output logic                          sweep_en_o,
    output logic [OBS_W-1:0]              obs_sel_o,
    output logic [INT_W-1:0]              int_o,
    output logic [FRAC_W-1:0]             frac_o,
    output logic [RCNT_W-1:0]             ref_cnt_o,
    output logic [PUMP_W-1:0]             pump_cur_o,
    output logic                          ref_half_o,
    output logic                          ref_dbl_o,
    output logic [STEP_W-1:0]             step_div_o,
    output logic [NUM_AUX-1:0][PAY_W-1:0] aux_o,
    output logic                          sdm_rst_o
);
    logic [2:0]        lvl;
    logic [2:0]        rise;
    logic [WORD_W-1:0] wr_word;
    logic              wr_stb;

    sbk_sync_edge #(.W(3), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({ser_ld_i, ser_clk_i, ser_dat_i}),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    sbk_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (lvl[0]),
        .shift_i (rise[1]),
        .load_i  (rise[2]),
        .word_o  (wr_word),
        .stb_o   (wr_stb)
    );

    sbk_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb_i   (wr_stb),
        .wr_word_i  (wr_word),
        .sweep_en_o (sweep_en_o),
        .obs_sel_o  (obs_sel_o),
        .int_o      (int_o),
        .frac_o     (frac_o),
        .ref_cnt_o  (ref_cnt_o),
        .pump_cur_o (pump_cur_o),
        .ref_half_o (ref_half_o),
        .ref_dbl_o  (ref_dbl_o),
        .step_div_o (step_div_o),
        .aux_o      (aux_o),
        .sdm_rst_o  (sdm_rst_o)
    );
endmodule

// File: rtl/sbk_checker.sv
// Temporal checks for the serial register bank, bound to sbk_top.
// Assumes access to the internal word strobe and word.
module sbk_checker
    import sbk_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_stb,
    input logic [WORD_W-1:0]             wr_word,
    input logic [FRAC_W-1:0]             frac_o,
    input logic [RCNT_W-1:0]             ref_cnt_o,
    input logic [PUMP_W-1:0]             pump_cur_o,
    input logic                          ref_half_o,
    input logic                          ref_dbl_o,
    input logic [STEP_W-1:0]             step_div_o,
    input logic [NUM_AUX-1:0][PAY_W-1:0] aux_o,
    input logic                          sdm_rst_o
);
    p_frac_lsb_dbuf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frac_o[FLSB_W-1:0]) |-> $past(wr_stb && wr_word[2:0] == 3'd0));

    p_ref_fields_dbuf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ref_cnt_o, pump_cur_o, ref_half_o, ref_dbl_o})
        |-> $past(wr_stb && wr_word[2:0] == 3'd0));

    p_step_div_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(step_div_o) |-> $past(wr_stb && wr_word[2:0] == 3'd2));

    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sdm_rst_o |-> $past(wr_stb && wr_word[2:0] == 3'd0 && !aux_o[0][HOLD_IDX]));

    p_pulse_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && wr_word[2:0] == 3'd0 && !aux_o[0][HOLD_IDX]) |-> sdm_rst_o);

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sdm_rst_o |=> !sdm_rst_o);
endmodule

bind sbk_top sbk_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_word    (wr_word),
    .frac_o     (frac_o),
    .ref_cnt_o  (ref_cnt_o),
    .pump_cur_o (pump_cur_o),
    .ref_half_o (ref_half_o),
    .ref_dbl_o  (ref_dbl_o),
    .step_div_o (step_div_o),
    .aux_o      (aux_o),
    .sdm_rst_o  (sdm_rst_o)
);

// File: tb/sbk_top_bench.sv
// Scoreboard bench: the driver queues expected snapshots with due cycles; the monitor compares them.
module sbk_top_bench;
    import sbk_pkg::*;

    localparam int SNAP_W = 1 + OBS_W + INT_W + FRAC_W + RCNT_W + PUMP_W + 2 + STEP_W
                          + NUM_AUX * PAY_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
    logic                          sweep_en, ref_half, ref_dbl, sdm_rst;
    logic [OBS_W-1:0]              obs_sel;
    logic [INT_W-1:0]              int_v;
    logic [FRAC_W-1:0]             frac;
    logic [RCNT_W-1:0]             ref_cnt;
    logic [PUMP_W-1:0]             pump;
    logic [STEP_W-1:0]             step_div;
    logic [NUM_AUX-1:0][PAY_W-1:0] aux;

    always #4 clk = ~clk;   // 125 MHz

    sbk_top u_sbk_top (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_ld_i(ser_ld),
        .sweep_en_o(sweep_en), .obs_sel_o(obs_sel), .int_o(int_v), .frac_o(frac),
        .ref_cnt_o(ref_cnt), .pump_cur_o(pump), .ref_half_o(ref_half), .ref_dbl_o(ref_dbl),
        .step_div_o(step_div), .aux_o(aux), .sdm_rst_o(sdm_rst)
    );

    typedef struct {
        int                due;
        logic [SNAP_W-1:0] exp;
        string             tag;
    } item_t;
    item_t q[$];

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference model state, written from the requirements.
    logic                          m_sweep = 0;
    logic [OBS_W-1:0]              m_obs = 0;
    logic [INT_W-1:0]              m_int = 0;
    logic [FMSB_W-1:0]             m_fmsb = 0;
    logic [FLSB_W-1:0]             m_flsb_s = 0, m_flsb_a = 0;
    logic [RCNT_W-1:0]             m_rcnt_s = 0, m_rcnt_a = 0;
    logic [PUMP_W-1:0]             m_pump_s = 0, m_pump_a = 0;
    logic                          m_half_s = 0, m_half_a = 0, m_dbl_s = 0, m_dbl_a = 0;
    logic [STEP_W-1:0]             m_step = 0;
    logic [NUM_AUX-1:0][PAY_W-1:0] m_aux = '0;

    function automatic logic [SNAP_W-1:0] snap(input logic pulse);
        logic [FRAC_W-1:0] f;
        f = FRAC_W'(m_flsb_a) + (FRAC_W'(m_fmsb) << 13);   // R4 composition
        return {m_sweep, m_obs, m_int, f, m_rcnt_a, m_pump_a, m_half_a, m_dbl_a,
                m_step, m_aux, pulse};
    endfunction

    task automatic push(input int due, input logic pulse, input string tag);
        item_t it;
        it.due = due; it.exp = snap(pulse); it.tag = tag;
        q.push_back(it);
    endtask

    // Driver: serial transfer of one word, model update, queue two items.
    task automatic write_word(input logic [31:0] w, input string tag);
        logic pulse;
        int due;
        for (int b = 31; b >= 0; b--) begin
            ser_dat = w[b];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (2) @(negedge clk);
        pulse = 1'b0;
        case (w[2:0])
            3'd0: begin
                pulse = ~m_aux[0][11];   // register 3 bit 14
                m_sweep = w[31]; m_obs = w[30:27]; m_int = w[26:15]; m_fmsb = w[14:3];
                m_flsb_a = m_flsb_s; m_rcnt_a = m_rcnt_s; m_pump_a = m_pump_s;
                m_half_a = m_half_s; m_dbl_a = m_dbl_s;
            end
            3'd1: m_flsb_s = w[27:15];
            3'd2: begin
                m_pump_s = w[27:24]; m_half_s = w[21]; m_dbl_s = w[20];
                m_rcnt_s = w[19:15]; m_step = w[14:3];
            end
            default: m_aux[w[2:0] - 3'd3] = w[31:3];
        endcase
        ser_ld = 1'b1;
        due = cyc + 3;               // R9: two sync flops plus one register stage
        push(due, pulse, tag);
        push(due + 1, 1'b0, {tag, " R7 pulse ends"});
        repeat (4) @(negedge clk);
        ser_ld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] w_r0(input logic sw, input logic [3:0] ob,
                                         input logic [11:0] iv, input logic [11:0] fm);
        return {sw, ob, iv, fm, 3'd0};
    endfunction
    function automatic logic [31:0] w_r1(input logic [12:0] fl);
        return {4'd0, fl, 12'd0, 3'd1};
    endfunction
    function automatic logic [31:0] w_r2(input logic [3:0] pc, input logic hv, input logic db,
                                         input logic [4:0] rc, input logic [11:0] md);
        return {4'd0, pc, 2'd0, hv, db, rc, md, 3'd2};
    endfunction

    // Monitor: compares the head item in its due cycle, away from the rising edge.
    always @(negedge clk) begin
        if (q.size() != 0 && q[0].due == cyc) begin
            logic [SNAP_W-1:0] act;
            item_t it;
            it = q.pop_front();
            act = {sweep_en, obs_sel, int_v, frac, ref_cnt, pump, ref_half, ref_dbl,
                   step_div, aux, sdm_rst};
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        push(cyc, 1'b0, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        push(cyc, 1'b0, "R1 state after reset release");
        @(negedge clk);
        write_word(w_r0(1'b1, 4'hA, 12'd181, 12'h5A3), "R2 R3 first register 0 write");
        write_word(w_r1(13'h1ABC), "R5 register 1 write held in shadow");
        write_word(w_r2(4'h9, 1'b1, 1'b1, 5'd17, 12'd125), "R5 R6 register 2 write");
        write_word(w_r0(1'b0, 4'h3, 12'hFFF, 12'h001), "R4 R5 commit on register 0");
        write_word({17'd0, 1'b1, 11'd0, 3'd3}, "R8 register 3 hold bit set");
        write_word(w_r0(1'b1, 4'hF, 12'd23, 12'hFFF), "R7 no pulse with hold set");
        write_word({17'd0, 1'b0, 11'h2A5, 3'd3}, "R8 register 3 hold cleared");
        write_word(32'hDEADBEEF | 32'd7, "R8 register 7 payload");
        write_word(32'h1234_5678 | 32'd5, "R8 register 5 payload");
        write_word(w_r1(13'h1FFF), "R5 max lower fraction in shadow");
        write_word(w_r2(4'h0, 1'b0, 1'b0, 5'd31, 12'hFFF), "R6 register 2 second write");
        write_word(w_r0(1'b0, 4'h0, 12'h000, 12'hFFF), "R4 R7 max fraction commit with pulse");
        write_word(32'hA5A5_A5A0 | 32'd4, "R2 R8 register 4 pattern");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad + q.size());
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule